// File: doc/BRIEF.md
# Two-Channel Double-Buffered Converter Register Front End

This block sits between a parallel host bus and a two-channel digital-to-analog converter core. The host writes a 12-bit code into a staging register for one channel, using an address bit to choose the channel. A write happens only when an active-low select and an active-low write enable are both held low. When that combined strobe is released, the code is committed. A separate active-low load input moves both staging registers into the converter registers in the same clock cycle, so the two analog outputs can change together.

All bus and control pins are treated as asynchronous to the system clock. Each is brought into the clock domain through a chain of flops before it acts. An active-low clear zeroes every register at once, without waiting for a clock. An active-low power-down input drives a single flag that covers both channels and leaves the stored codes unchanged.

Top module: `dual_dac_regif`

## Requirements
- R1: While `clr_n` is low, every staging register and every converter register reads zero on `dac_val`, and this takes effect at once without a clock edge.
- R2: A write takes place only when `cs_n` and `wr_n` are low at the same time. A pulse on only one of the two leaves both staging registers unchanged.
- R3: A write commits on release of the combined strobe. The staging register takes the `addr` and `data` present at the third rising clock edge after the release. `addr` and `data` must be held stable until that edge. Each strobe produces exactly one write.
- R4: `addr` = 0 writes channel 0, and `addr` = 1 writes channel 1. A write never touches the other channel.
- R5: Channel k appears on `dac_val[k*12 +: 12]`, with data bit 11 as the MSB of that slice. The slice for channel 0 is bits 11..0 and the slice for channel 1 is bits 23..12.
- R6: When `load_n` goes low, both converter registers take their staging values at the third rising clock edge. Both channels update on the same edge.
- R7: While `load_n` is high, the converter registers hold their value even when a staging register is written.
- R8: Clear has priority over write and load. Strobes and loads made while `clr_n` is low have no effect, and all registers stay zero after release until a new write and load.
- R9: `pwr_down` goes high two rising clock edges after `pd_n` falls and goes low again two edges after `pd_n` rises. It does not change `dac_val`, and writes and loads still work while it is set.
- R10: While `load_n` is held low, a committed write reaches `dac_val` one clock edge after the staging register takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write enable, active low |
| addr | input | 1 | Channel select for writes |
| data | input | 12 | Write data, bit 11 is the MSB |
| load_n | input | 1 | Load staging registers into converter registers, active low |
| pd_n | input | 1 | Power-down request, active low |
| dac_val | output | 24 | Converter register values, channel k at [k*12 +: 12] |
| pwr_down | output | 1 | Power-down flag for both channels |

## Verification
Random writes go to random channels with random codes. They are mixed with load pulses, so a value from the staging register is told apart from a value that was moved on. Strobes that drive only select or only write enable, followed by a load, tell a real write from a partial strobe. A load held low during a write tells follow mode from hold mode. Edge-exact samples around a load and a write-release pin down the three-edge latency. A clear asserted mid-cycle, and strobes made while clear is low, show that clear is asynchronous and has priority. Power-down toggles placed between data operations show that the flag leaves the stored codes alone.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

   // Smallest synchroniser depth accepted by the block
   localparam int unsigned DACIF_MIN_SYNC = 2;

   // Converter register update mode
   typedef enum logic {
      LD_HOLD   = 1'b0,
      LD_FOLLOW = 1'b1
   } ld_mode_e;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   import dacif_pkg::*;

   initial begin
      assert (STAGES >= DACIF_MIN_SYNC)
         else $error("dacif_sync: STAGES must be at least %0d", DACIF_MIN_SYNC);
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) sh_q <= {STAGES{RST_VAL}};
      else         sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/dacif_strobe.sv
module dacif_strobe #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic cs_n,
   input  logic wr_n,
   output logic commit
);
   logic req_raw;
   logic req_s;
   logic req_prev_q;

   assign req_raw = ~cs_n & ~wr_n;

   dacif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (req_raw),
      .q      (req_s)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) req_prev_q <= 1'b0;
      else         req_prev_q <= req_s;
   end

   // release of the synchronised strobe
   assign commit = req_prev_q & ~req_s;

   // R3
   single_commit_chk: assert property (@(posedge clk) disable iff (!arst_n)
      commit |=> !commit);

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  dacif_pkg::ld_mode_e ld_mode,
   output logic [DATA_W-1:0] dac_q
);
   import dacif_pkg::*;

   logic [DATA_W-1:0] in_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)    in_q <= '0;
      else if (wr_en) in_q <= wdata;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)                 dac_q <= '0;
      else if (ld_mode == LD_FOLLOW) dac_q <= in_q;
   end

   // R2
   stage_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !wr_en |=> $stable(in_q));

   // R3
   stage_load_chk: assert property (@(posedge clk) disable iff (!arst_n)
      wr_en |=> in_q == $past(wdata));

   // R6
   dac_follow_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (ld_mode == LD_FOLLOW) |=> dac_q == $past(in_q));

   // R7
   dac_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (ld_mode == LD_HOLD) |=> $stable(dac_q));

endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif #(
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned OUT_W      = NUM_CH * DATA_W
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              load_n,
   input  logic              pd_n,
   output logic [OUT_W-1:0]  dac_val,
   output logic              pwr_down
);
   import dacif_pkg::*;

   initial begin
      assert (DATA_W >= 1)  else $error("dual_dac_regif: DATA_W must be positive");
      assert (NUM_CH >= 2)  else $error("dual_dac_regif: NUM_CH must be at least 2");
      assert (SYNC_STAGES >= DACIF_MIN_SYNC)
         else $error("dual_dac_regif: SYNC_STAGES too small");
   end

   logic              commit;
   logic              load_s;
   logic              pd_s;
   ld_mode_e          ld_mode;
   logic [NUM_CH-1:0] wr_en;

   dacif_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
      .clk    (clk),
      .arst_n (clr_n),
      .cs_n   (cs_n),
      .wr_n   (wr_n),
      .commit (commit)
   );

   dacif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_load_sync (
      .clk    (clk),
      .arst_n (clr_n),
      .d      (load_n),
      .q      (load_s)
   );

   dacif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
      .clk    (clk),
      .arst_n (clr_n),
      .d      (pd_n),
      .q      (pd_s)
   );

   assign ld_mode  = load_s ? LD_HOLD : LD_FOLLOW;
   assign pwr_down = ~pd_s;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      assign wr_en[k] = commit && (addr == ADDR_W'(k));

      dacif_chan #(.DATA_W(DATA_W)) u_chan (
         .clk     (clk),
         .arst_n  (clr_n),
         .wr_en   (wr_en[k]),
         .wdata   (data),
         .ld_mode (ld_mode),
         .dac_q   (dac_val[k*DATA_W +: DATA_W])
      );
   end

   // R4
   one_target_chk: assert property (@(posedge clk) disable iff (!clr_n)
      $onehot0(wr_en));

   // R4
   commit_hits_chk: assert property (@(posedge clk) disable iff (!clr_n)
      commit |-> (wr_en != '0) || (addr >= ADDR_W'(NUM_CH - 1) && NUM_CH != (1 << ADDR_W)));

endmodule

// File: tb/sim_dual_dac_regif.sv
`timescale 1ns/1ps
module sim_dual_dac_regif;
   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          clr_n = 1'b0;
   logic          cs_n = 1'b1, wr_n = 1'b1;
   logic [0:0]    addr = '0;
   logic [DW-1:0] data = '0;
   logic          load_n = 1'b1, pd_n = 1'b1;
   logic [2*DW-1:0] dac_val;
   logic          pwr_down;

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] exp_in [2];
   logic [DW-1:0] exp_dac [2];
   logic          exp_pd;

   always #2 clk = ~clk;

   dual_dac_regif u0 (
      .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
      .data(data), .load_n(load_n), .pd_n(pd_n), .dac_val(dac_val),
      .pwr_down(pwr_down)
   );

   function automatic logic [2*DW-1:0] exp_out();
      return {exp_dac[1], exp_dac[0]};
   endfunction

   task automatic check_out(string req);
      n_chk++;
      if (dac_val !== exp_out()) begin
         n_fail++;
         $display("FAIL %s dac_val actual %h expected %h", req, dac_val, exp_out());
      end
   endtask

   task automatic check_pd(string req);
      n_chk++;
      if (pwr_down !== exp_pd) begin
         n_fail++;
         $display("FAIL %s pwr_down actual %b expected %b", req, pwr_down, exp_pd);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // strobe: mode 0 full write, 1 cs only, 2 wr only
   task automatic bus_write(logic a, logic [DW-1:0] d, int mode);
      @(negedge clk);
      addr = a; data = d;
      cs_n = (mode == 2); wr_n = (mode == 1);
      idle(3);
      cs_n = 1'b1; wr_n = 1'b1;
      idle(6);
      if (mode == 0) begin
         exp_in[a] = d;
         if (!load_n) exp_dac[a] = d;
      end
   endtask

   task automatic load_pulse();
      @(negedge clk);
      load_n = 1'b0;
      idle(4);
      load_n = 1'b1;
      idle(4);
      exp_dac[0] = exp_in[0];
      exp_dac[1] = exp_in[1];
   endtask

   task automatic clear_model();
      exp_in[0] = '0; exp_in[1] = '0; exp_dac[0] = '0; exp_dac[1] = '0;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      clear_model();
      exp_pd = 1'b0;
      idle(3);
      check_out("R1 reset");
      check_pd("R9 reset");
      clr_n = 1'b1;
      idle(2);

      // R4 R5 directed: distinct patterns on each channel
      bus_write(1'b0, 12'hA5C, 0);
      bus_write(1'b1, 12'h3E1, 0);
      check_out("R7 staging hidden");
      load_pulse();
      check_out("R4 R5 both channels");
      bus_write(1'b1, 12'h800, 0);
      load_pulse();
      check_out("R5 msb slice");

      // R2 partial strobes
      bus_write(1'b0, 12'hFFF, 1);
      bus_write(1'b1, 12'h111, 2);
      load_pulse();
      check_out("R2 partial strobe");

      // R6 exact latency
      bus_write(1'b0, 12'h0F0, 0);
      @(negedge clk);
      load_n = 1'b0;
      @(negedge clk); check_out("R6 edge1 hold");
      @(negedge clk); check_out("R6 edge2 hold");
      @(negedge clk);
      exp_dac[0] = exp_in[0]; exp_dac[1] = exp_in[1];
      check_out("R6 edge3 update");

      // R3 R10 exact latency with load held low
      addr = 1'b1; data = 12'h6B7;
      cs_n = 1'b0; wr_n = 1'b0;
      idle(3);
      cs_n = 1'b1; wr_n = 1'b1;
      @(negedge clk); @(negedge clk); @(negedge clk);
      check_out("R3 before commit");
      @(negedge clk);
      exp_in[1] = 12'h6B7; exp_dac[1] = 12'h6B7;
      check_out("R10 follow after commit");
      idle(4);
      check_out("R3 single write");
      load_n = 1'b1;
      idle(4);

      // R7 hold while load high
      bus_write(1'b0, 12'h2D2, 0);
      check_out("R7 hold");

      // R9 power down does not disturb codes
      @(negedge clk); pd_n = 1'b0;
      @(negedge clk); check_pd("R9 edge1");
      @(negedge clk); exp_pd = 1'b1; check_pd("R9 edge2");
      check_out("R9 codes kept");
      bus_write(1'b1, 12'hC3C, 0);
      load_pulse();
      check_out("R9 write while down");
      @(negedge clk); pd_n = 1'b1;
      idle(2); exp_pd = 1'b0; check_pd("R9 release");

      // R1 asynchronous clear mid-cycle
      @(negedge clk);
      #1 clr_n = 1'b0;
      #0.5;
      clear_model();
      check_out("R1 async clear");

      // R8 clear priority
      bus_write(1'b0, 12'h777, 0);
      clear_model();
      load_pulse();
      clear_model();
      check_out("R8 ops during clear");
      @(negedge clk); clr_n = 1'b1;
      idle(4);
      check_out("R8 after release");

      // random mix
      for (int it = 0; it < 60; it++) begin
         int op;
         op = $urandom_range(0, 5);
         case (op)
            0, 1: bus_write(1'($urandom_range(0, 1)), 12'($urandom), 0);
            2:    bus_write(1'($urandom_range(0, 1)), 12'($urandom), $urandom_range(1, 2));
            3:    load_pulse();
            4: begin
               @(negedge clk); pd_n = ~pd_n;
               idle(3); exp_pd = ~pd_n;
               check_pd("R9 random");
            end
            default: begin
               load_n = 1'b0;
               exp_dac[0] = exp_in[0]; exp_dac[1] = exp_in[1];
               bus_write(1'($urandom_range(0, 1)), 12'($urandom), 0);
               load_n = 1'b1;
               idle(4);
            end
         endcase
         check_out("R4 R7 R10 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule